// File: doc/BRIEF.md
# Mirrored Sprite Line Shift Register

This block turns one scanline of a small ship sprite into a serial pixel stream. A combinational lookup takes the line index inside the sprite, a flag that marks the space variant of the game and a two-bit sprite select. From these it produces only the left half of the row, six bits. A fixed pairing spreads those six bits over twelve register cells, so every row comes out left-right symmetric without storing its right half.

The row is loaded when the owning object's position counter hits its trigger point (`trigger` together with a pixel enable). It then moves out one cell per pixel enable, with zeros entering behind it. The serial bit is steered to one of three per-ship lanes, chosen by the select captured at load time. A test input forces the active lane high, which paints solid bars.

Top module: `sprite_line_gen`

## Requirements
- R1: While `rst_n` is low, and after its release until the first load, the register is empty and the captured select is 0. `ship_out` is therefore 0, or 3'b001 if `test_force` is high.
- R2: A rising clock edge with `pix_en` and `trigger` both high loads the row. Right after that edge, the active lane shows cell 0, the leftmost pixel.
- R3: Every loaded row is symmetric. Cell i equals cell 11-i, so pixel k of the stream equals pixel 11-k.
- R4: In normal mode each row is a centred run of ones of width 2*w, so cell c is 1 when 6-w <= c < 6+w. For lines 0 to 7, w is: select 0: 1,1,2,6,6,6,5,4. Select 1: 0,1,3,3,6,6,5,3. Select 2: 0,0,1,1,5,6,6,5.
- R5: In space mode (`space_mode`=1), select 0 uses w = 6,1,2,3,3,2,1,6 and select 1 uses w = 1,2,4,6,6,4,2,1. Select 2 loads an empty row.
- R6: A line index of 8 or more loads an all-zero row.
- R7: The register shifts only on clock edges where `pix_en` is high. Otherwise the register and the captured select hold, and `trigger` without `pix_en` has no effect.
- R8: Zeros enter on each shift. After 12 shifts following a load, the output stays 0 until the next load.
- R9: The serial bit drives only `ship_out[s]`, where s is the select captured at load. Select 3 drives no lane, so `ship_out` never has more than one bit set.
- R10: `test_force` high drives the captured select's lane to 1 regardless of register contents.
- R11: A load during an ongoing row restarts the stream with the new row and select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel clock enable; one pixel per enabled cycle |
| trigger | input | 1 | Position counter reached its trigger point |
| line_idx | input | 4 | Line within the sprite (0..7 valid) |
| space_mode | input | 1 | Selects the space variant shapes |
| ship_sel | input | 2 | Sprite select (0..2 ships, 3 none) |
| test_force | input | 1 | Force the active lane high |
| ship_out | output | 3 | Per-ship pixel lanes |

## Verification
The assertions assume that `trigger` matters only on a pixel-enabled edge. They also assume that the row and select inputs are settled before that edge, and that the bit-reversal symmetry of a freshly loaded row holds for every input combination, including out-of-range lines. The stimulus changes every input on the falling clock edge only. It sweeps all sprite selects, both modes and line indices 0 to 9 and 15. It inserts pixel-enable gaps and triggers without an enable, so every input stays within those assumptions while still reaching the empty-row and no-lane cases.

// File: rtl/sprite_pkg.sv
package sprite_pkg;
  localparam int PROFILE_LINES = 8;
  localparam int WIDTH_BITS    = 3;
  typedef logic [WIDTH_BITS-1:0] width_t;
  typedef logic [PROFILE_LINES*WIDTH_BITS-1:0] profile_t;

  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_NONE = 2'd3
  } sprite_sel_e;

  // Half-row width for one line; line 0 sits in the lowest field.
  function automatic width_t width_at(input profile_t prof, input int line);
    return prof[line*WIDTH_BITS +: WIDTH_BITS];
  endfunction

  // Half row anchored at the centre: bit j (0 = outer end) is set when the
  // run of width w reaches it.
  function automatic logic [7:0] half_from_width(input width_t w, input int half);
    logic [7:0] h;
    h = '0;
    for (int j = 0; j < 8; j++)
      if (j < half && j >= half - int'(w)) h[j] = 1'b1;
    return h;
  endfunction
endpackage

// File: rtl/sprite_row_lut.sv
module sprite_row_lut
  import sprite_pkg::*;
#(
  parameter int LINE_W       = 4,
  parameter int SPRITE_LINES = 8,
  parameter int HALF         = 6
) (
  input  logic [LINE_W-1:0] line_idx,
  input  logic              space_mode,
  input  logic [1:0]        ship_sel,
  output logic [HALF-1:0]   half_bits
);
  // Width profiles, line 7 on the left.
  localparam profile_t PROF_S0 = {3'd4,3'd5,3'd6,3'd6,3'd6,3'd2,3'd1,3'd1};
  localparam profile_t PROF_S1 = {3'd3,3'd5,3'd6,3'd6,3'd3,3'd3,3'd1,3'd0};
  localparam profile_t PROF_S2 = {3'd5,3'd6,3'd6,3'd5,3'd1,3'd1,3'd0,3'd0};
  localparam profile_t PROF_P0 = {3'd6,3'd1,3'd2,3'd3,3'd3,3'd2,3'd1,3'd6};
  localparam profile_t PROF_P1 = {3'd1,3'd2,3'd4,3'd6,3'd6,3'd4,3'd2,3'd1};
  localparam int LIMIT = (SPRITE_LINES < PROFILE_LINES) ? SPRITE_LINES : PROFILE_LINES;

  logic   line_ok;
  int     line_n;
  width_t w_s0, w_s1, w_s2, w_p0, w_p1, w_sel;
  logic [7:0] half_full;

  always_comb begin
    line_n  = int'(line_idx);
    line_ok = line_n < LIMIT;
    // Line-dependent features, shared across selects.
    w_s0 = line_ok ? width_at(PROF_S0, line_n) : '0;
    w_s1 = line_ok ? width_at(PROF_S1, line_n) : '0;
    w_s2 = line_ok ? width_at(PROF_S2, line_n) : '0;
    w_p0 = line_ok ? width_at(PROF_P0, line_n) : '0;
    w_p1 = line_ok ? width_at(PROF_P1, line_n) : '0;
    // Combine with the sprite select.
    unique case (sprite_sel_e'(ship_sel))
      SEL_A:   w_sel = space_mode ? w_p0 : w_s0;
      SEL_B:   w_sel = space_mode ? w_p1 : w_s1;
      SEL_C:   w_sel = space_mode ? '0   : w_s2;
      default: w_sel = '0;
    endcase
    half_full = half_from_width(w_sel, HALF);
    half_bits = half_full[HALF-1:0];
  end
endmodule

// File: rtl/mirror_fill.sv
module mirror_fill #(
  parameter int CELLS = 12,
  localparam int HALF = CELLS / 2
) (
  input  logic [HALF-1:0]  half_bits,
  output logic [CELLS-1:0] cells
);
  // Cell i and cell CELLS-1-i share one half bit: end pair from bit 0,
  // centre pair from bit HALF-1.
  for (genvar i = 0; i < CELLS; i++) begin : g_pair
    if (i < HALF) begin : g_left
      assign cells[i] = half_bits[i];
    end else begin : g_right
      assign cells[i] = half_bits[CELLS-1-i];
    end
  end
endmodule

// File: rtl/line_shifter.sv
module line_shifter #(
  parameter int CELLS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic [CELLS-1:0] cells_in,
  output logic [CELLS-1:0] sr,
  output logic             ser_bit
);
  always_ff @(posedge clk) begin
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= cells_in;
    else if (shift) sr <= {1'b0, sr[CELLS-1:1]};
  end
  assign ser_bit = sr[0];
endmodule

// File: rtl/sprite_line_gen.sv
module sprite_line_gen
  import sprite_pkg::*;
#(
  parameter int CELLS        = 12,
  parameter int LINE_W       = 4,
  parameter int SPRITE_LINES = 8,
  parameter int SHIPS        = 3,
  localparam int HALF        = CELLS / 2,
  localparam int SEL_W       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic              trigger,
  input  logic [LINE_W-1:0] line_idx,
  input  logic              space_mode,
  input  logic [SEL_W-1:0]  ship_sel,
  input  logic              test_force,
  output logic [SHIPS-1:0]  ship_out
);
  logic [HALF-1:0]  half_bits;
  logic [CELLS-1:0] cells;
  logic [CELLS-1:0] sr;
  logic             ser_bit;
  logic             load_evt;
  logic             shift_evt;
  logic             lane_bit;
  logic [SEL_W-1:0] sel_q;

  assign load_evt  = pix_en && trigger;
  assign shift_evt = pix_en && !trigger;

  sprite_row_lut #(.LINE_W(LINE_W), .SPRITE_LINES(SPRITE_LINES), .HALF(HALF)) u_lut (
    .line_idx(line_idx), .space_mode(space_mode), .ship_sel(ship_sel),
    .half_bits(half_bits)
  );

  mirror_fill #(.CELLS(CELLS)) u_mirror (.half_bits(half_bits), .cells(cells));

  line_shifter #(.CELLS(CELLS)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load_evt), .shift(shift_evt),
    .cells_in(cells), .sr(sr), .ser_bit(ser_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        sel_q <= '0;
    else if (load_evt) sel_q <= ship_sel;
  end

  assign lane_bit = ser_bit || test_force;

  for (genvar k = 0; k < SHIPS; k++) begin : g_lane
    assign ship_out[k] = lane_bit && (int'(sel_q) == k);
  end
endmodule

// File: rtl/sprite_line_chk.sv
module sprite_line_chk #(
  parameter int CELLS = 12,
  parameter int SHIPS = 3,
  parameter int LINE_W = 4,
  parameter int SPRITE_LINES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_en,
  input logic              trigger,
  input logic              test_force,
  input logic [LINE_W-1:0] line_idx,
  input logic [SHIPS-1:0]  ship_out,
  input logic [CELLS-1:0]  sr,
  input logic [1:0]        sel_q
);
  function automatic logic [CELLS-1:0] rev(input logic [CELLS-1:0] v);
    logic [CELLS-1:0] r;
    for (int i = 0; i < CELLS; i++) r[i] = v[CELLS-1-i];
    return r;
  endfunction

  // R3
  mirror_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && trigger) |=> (sr == rev(sr)));

  // R6
  blank_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && trigger && int'(line_idx) >= SPRITE_LINES) |=> (sr == '0));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(sr) && $stable(sel_q)));

  // R8
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && !trigger) |=> (sr[CELLS-1] == 1'b0));

  // R9
  one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ship_out));

  // R10
  force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_force && int'(sel_q) < SHIPS) |-> (ship_out != '0));
endmodule

bind sprite_line_gen sprite_line_chk #(
  .CELLS(CELLS), .SHIPS(SHIPS), .LINE_W(LINE_W), .SPRITE_LINES(SPRITE_LINES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .trigger(trigger),
  .test_force(test_force), .line_idx(line_idx), .ship_out(ship_out),
  .sr(sr), .sel_q(sel_q)
);

// File: tb/sim_sprite_line_gen.sv
module sim_sprite_line_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pix_en, trigger, space_mode, test_force;
  logic [3:0] line_idx;
  logic [1:0] ship_sel;
  logic [2:0] ship_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  sprite_line_gen u0 (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .trigger(trigger),
    .line_idx(line_idx), .space_mode(space_mode), .ship_sel(ship_sel),
    .test_force(test_force), .ship_out(ship_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Widths from R4 / R5, indexed [shape][line].
  int wtab [5][8] = '{
    '{1,1,2,6,6,6,5,4},
    '{0,1,3,3,6,6,5,3},
    '{0,0,1,1,5,6,6,5},
    '{6,1,2,3,3,2,1,6},
    '{1,2,4,6,6,4,2,1}
  };

  function automatic int half_width(input bit sp, input int sel, input int line);
    if (line >= 8 || sel == 3) return 0;
    if (sp) return (sel == 2) ? 0 : wtab[3 + sel][line];
    return wtab[sel][line];
  endfunction

  // Centred run of 2*w ones over pixels 0..11; pixel 12+ empty.
  function automatic bit pix_exp(input int w, input int k);
    return (k < 12) && (k >= 6 - w) && (k < 6 + w);
  endfunction

  function automatic logic [2:0] lane(input bit b, input int sel);
    return (b && sel < 3) ? (3'b001 << sel) : 3'b000;
  endfunction

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: ship_out=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic load_row(input bit sp, input int sel, input int line);
    @(negedge clk);
    space_mode = sp; ship_sel = 2'(sel); line_idx = 4'(line);
    pix_en = 1'b1; trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
  endtask

  // Sweep R2..R6, R8, R9: 13 pixels per row, one check per row.
  task automatic stream_row(input bit sp, input int sel, input int line);
    logic [2:0] got [13];
    bit ok = 1;
    bit sym = 1;
    int w = half_width(sp, sel, line);
    load_row(sp, sel, line);
    for (int k = 0; k < 13; k++) begin
      got[k] = ship_out;
      @(negedge clk);
    end
    for (int k = 0; k < 13; k++)
      if (got[k] !== lane(pix_exp(w, k), sel)) ok = 0;
    for (int k = 0; k < 12; k++)
      if (got[k] !== got[11-k]) sym = 0;
    checks++;
    if (!ok || !sym) begin
      failures++;
      $display("FAIL R4/R5/R6/R8/R9/R3 space=%0d sel=%0d line=%0d: first pixel %b expected %b, symmetric=%0d",
               sp, sel, line, got[0], lane(pix_exp(w, 0), sel), sym);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pix_en = 1'b0; trigger = 1'b0; space_mode = 1'b0;
    test_force = 1'b0; line_idx = '0; ship_sel = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 empty in reset", ship_out, 3'b000);
    test_force = 1'b1;
    @(negedge clk);
    check("R1 reset select 0", ship_out, 3'b001);
    test_force = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", ship_out, 3'b000);

    // Sweep all modes, selects and lines (R2, R3, R4, R5, R6, R8, R9)
    for (int sp = 0; sp < 2; sp++)
      for (int sel = 0; sel < 4; sel++) begin
        for (int line = 0; line < 10; line++) stream_row(sp[0], sel, line);
        stream_row(sp[0], sel, 15);
      end

    // R2: first pixel of select 1 line 4 (w=6) is on
    load_row(1'b0, 1, 4);
    check("R2 first pixel", ship_out, 3'b010);
    // R7: enable gap holds the pixel; trigger without enable ignored
    pix_en = 1'b0;
    line_idx = 4'd0; ship_sel = 2'd2; trigger = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 hold across gap", ship_out, 3'b010);
    trigger = 1'b0;
    // R11: reload mid-row with select 2 line 0 (empty) then line 4 (w=5)
    load_row(1'b0, 2, 4);
    check("R11 restart pixel 0", ship_out, 3'b000);
    pix_en = 1'b1;
    @(negedge clk);
    check("R11 restart pixel 1", ship_out, 3'b100);
    // R10 test force on captured lane over an empty register
    repeat (14) @(negedge clk);
    check("R8 drained", ship_out, 3'b000);
    test_force = 1'b1;
    @(negedge clk);
    check("R10 force lane 2", ship_out, 3'b100);
    test_force = 1'b0;
    // R9/R10: select 3 captured drives no lane even when forced
    load_row(1'b0, 3, 4);
    test_force = 1'b1;
    @(negedge clk);
    check("R10 no lane for select 3", ship_out, 3'b000);
    test_force = 1'b0;
    // R7: trigger without pix_en after drain leaves output empty
    load_row(1'b0, 0, 4);
    repeat (13) @(negedge clk);
    pix_en = 1'b0; trigger = 1'b1; line_idx = 4'd4;
    @(negedge clk);
    trigger = 1'b0;
    @(negedge clk);
    check("R7 trigger without enable", ship_out, 3'b000);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule